// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the system reset from already-digitized supervisor inputs: a synchronized flag that is high while the main supply sits above its trip level, a raw active-low push-button line, and a two-bit hold-time select. Reset stays asserted while the supply is low or the button is pressed. When both causes have cleared, it stays asserted for a further selectable number of clock cycles and then releases. One hold counter serves every cause: power-up, brownout and manual reset.

The button line passes through a two-flop synchronizer and a stability filter before it counts as a reset cause. A separate early-warning output follows the supply flag with no added delay. A build parameter sets whether reset is active high or active low. A set of timeout parameters gives three hold counts, and the fourth select code falls back to the first count.

Top module: `supv_reset_gen`

## Requirements
- R1: While the asynchronous block reset `rstN` is low, reset is asserted. After `rstN` rises, reset is held and then released only through the normal hold sequence.
- R2: If `supplyOk` is sampled low at a rising clock edge, reset is asserted after that edge.
- R3: `manRstN` first goes through two synchronizing flops. A new level is accepted only after the synchronized value has differed from the accepted level at `DEB_CYCLES` consecutive edges. A pulse shorter than that never affects reset.
- R4: Take the first rising edge at which no cause is present (supply ok and accepted button level high). Reset deasserts at the N-th such edge, counting that first edge as 1, where N is the selected hold count.
- R5: Hold select encoding: `holdSel`=0 selects `HOLD_A`, 1 selects `HOLD_B`, 2 selects `HOLD_C`, and 3 is reserved and selects `HOLD_A`.
- R6: A cause that appears during the hold interval clears the hold count. Timing starts again from the point where that cause clears.
- R7: `earlyWarnN` equals `supplyOk` combinationally in every cycle, with no hold delay.
- R8: With `RST_ACTIVE_HIGH`=1, `sysRst` is 1 while reset is asserted. With `RST_ACTIVE_HIGH`=0, it is 0 while reset is asserted.
- R9: When the supply and the button causes overlap, release is timed from whichever of them clears last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock |
| rstN | input | 1 | Asynchronous block reset, active low |
| supplyOk | input | 1 | Synchronized flag, high while the main supply is above its trip level |
| manRstN | input | 1 | Raw push-button reset line, active low |
| holdSel | input | 2 | Hold-time select code |
| sysRst | output | 1 | System reset, polarity set by `RST_ACTIVE_HIGH` |
| earlyWarnN | output | 1 | Undelayed supply-low warning, active low |

## Verification
The hardest state to reach from the ports is a button press that has been accepted by the filter while a supply-driven hold is already running. In that state the two causes overlap, and the release has to be timed from the later one. To get there, the stimulus drops the supply, holds the button low for longer than the filter window, restores the supply, and releases the button several cycles later. It also injects button glitches one cycle shorter than the window part-way through a hold, and changes the select code between hold intervals. A behavioural model built on integers and a queue predicts every cycle.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef struct packed {
    logic clearHold;  // a reset cause is present this cycle
    logic advance;    // no cause, hold interval running
  } holdStrobe_t;
endpackage

// File: rtl/supv_ctrl.sv
module supv_ctrl #(
  parameter int DEB_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  supplyOk,
  input  logic                  manRstN,
  input  logic                  rstActive,
  output supv_pkg::holdStrobe_t strobes
);
  localparam int DW = $clog2(DEB_CYCLES + 1);

  logic [1:0]    syncSh;
  logic          syncLvl;
  logic          mrStable;
  logic [DW-1:0] debCnt;
  logic          cause;

  assign syncLvl = syncSh[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncSh   <= 2'b11;
      mrStable <= 1'b1;
      debCnt   <= '0;
    end else begin
      syncSh <= {syncSh[0], manRstN};
      if (syncLvl != mrStable) begin
        if (debCnt == DW'(DEB_CYCLES - 1)) begin
          mrStable <= syncLvl;
          debCnt   <= '0;
        end else begin
          debCnt <= debCnt + 1'b1;
        end
      end else begin
        debCnt <= '0;
      end
    end
  end

  assign cause             = !supplyOk || !mrStable;
  assign strobes.clearHold = cause;
  assign strobes.advance   = !cause && rstActive;

  // R3
  deb_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mrStable) |-> $past(syncLvl != mrStable));

  // R3
  deb_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    debCnt < DW'(DEB_CYCLES));
endmodule

// File: rtl/supv_datapath.sv
module supv_datapath #(
  parameter int HOLD_A          = 8,
  parameter int HOLD_B          = 16,
  parameter int HOLD_C          = 32,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            holdSel,
  input  supv_pkg::holdStrobe_t strobes,
  output logic                  rstActive,
  output logic                  sysRst
);
  localparam int MAXAB = (HOLD_A > HOLD_B) ? HOLD_A : HOLD_B;
  localparam int MAXH  = (MAXAB > HOLD_C) ? MAXAB : HOLD_C;
  localparam int CW    = $clog2(MAXH + 1);

  logic [CW-1:0] holdCnt;
  logic [CW-1:0] holdTarget;

  always_comb begin
    unique case (holdSel)
      2'd1:    holdTarget = CW'(HOLD_B);
      2'd2:    holdTarget = CW'(HOLD_C);
      default: holdTarget = CW'(HOLD_A);  // 0 and reserved 3
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstActive <= 1'b1;
      holdCnt   <= '0;
    end else if (strobes.clearHold) begin
      rstActive <= 1'b1;
      holdCnt   <= '0;
    end else if (strobes.advance) begin
      if (holdCnt >= holdTarget - 1'b1) begin
        rstActive <= 1'b0;
        holdCnt   <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  generate
    if (RST_ACTIVE_HIGH) begin : g_high
      assign sysRst = rstActive;
    end else begin : g_low
      assign sysRst = !rstActive;
    end
  endgenerate

  // R2
  cause_asserts_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearHold |=> rstActive);

  // R6
  cause_clears_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearHold |=> (holdCnt == '0));

  // R4
  release_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstActive) |-> $past(strobes.advance));

  // R4
  hold_no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt < CW'(MAXH));
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int DEB_CYCLES      = 4,
  parameter int HOLD_A          = 8,
  parameter int HOLD_B          = 16,
  parameter int HOLD_C          = 32,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       manRstN,
  input  logic [1:0] holdSel,
  output logic       sysRst,
  output logic       earlyWarnN
);
  supv_pkg::holdStrobe_t strobes;
  logic                  rstActive;

  supv_ctrl #(.DEB_CYCLES(DEB_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .manRstN(manRstN),
    .rstActive(rstActive), .strobes(strobes)
  );

  supv_datapath #(
    .HOLD_A(HOLD_A), .HOLD_B(HOLD_B), .HOLD_C(HOLD_C),
    .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .holdSel(holdSel), .strobes(strobes),
    .rstActive(rstActive), .sysRst(sysRst)
  );

  assign earlyWarnN = supplyOk;

  // R7
  early_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    earlyWarnN == supplyOk);
endmodule

// File: tb/test_supv_reset_gen.sv
module test_supv_reset_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 4;
  localparam int HA   = 8;
  localparam int HB   = 16;
  localparam int HC   = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b0;
  logic manRstN = 1'b1;
  logic [1:0] holdSel = 2'd0;
  logic sysRst, earlyWarnN, sysRstLo, earlyWarnLo;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // reference model state
  int mAct = 1, mCnt = 0, mDeb = 0, mStable = 1;
  int syncQ[$] = '{1, 1};

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_reset_gen #(.DEB_CYCLES(DEB), .HOLD_A(HA), .HOLD_B(HB), .HOLD_C(HC),
    .RST_ACTIVE_HIGH(1'b1)) i_supv_reset_gen (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .manRstN(manRstN),
    .holdSel(holdSel), .sysRst(sysRst), .earlyWarnN(earlyWarnN));

  supv_reset_gen #(.DEB_CYCLES(DEB), .HOLD_A(HA), .HOLD_B(HB), .HOLD_C(HC),
    .RST_ACTIVE_HIGH(1'b0)) i_supv_reset_gen_lo (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .manRstN(manRstN),
    .holdSel(holdSel), .sysRst(sysRstLo), .earlyWarnN(earlyWarnLo));

  function automatic int holdFor(input logic [1:0] s);
    if (s == 2'd1) return HB;
    if (s == 2'd2) return HC;
    return HA;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAct = 1; mCnt = 0; mDeb = 0; mStable = 1; syncQ = '{1, 1};
    end else begin
      int lvl;
      lvl = syncQ[1];
      if (!supplyOk || mStable == 0) begin
        mAct = 1; mCnt = 0;
      end else if (mAct == 1) begin
        mCnt++;
        if (mCnt >= holdFor(holdSel)) begin mAct = 0; mCnt = 0; end
      end
      if (lvl != mStable) begin
        mDeb++;
        if (mDeb == DEB) begin mStable = lvl; mDeb = 0; end
      end else mDeb = 0;
      syncQ.push_front(int'(manRstN));
      void'(syncQ.pop_back());
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      check(curReq, sysRst, 1'(mAct));
      check("R8", sysRstLo, ~1'(mAct));
      check("R7", earlyWarnN, supplyOk);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    cyc(3);
    check("R1", sysRst, 1'b1);          // reset state
    check("R8", sysRstLo, 1'b0);
    rstN = 1'b1;
    cyc(2);
    curReq = "R1"; supplyOk = 1'b1;     // power-up hold
    cyc(HA + 4);
    check("R4", sysRst, 1'b0);
    curReq = "R2"; supplyOk = 1'b0; cyc(3);
    check("R2", sysRst, 1'b1);
    curReq = "R4"; supplyOk = 1'b1; cyc(HA - 1);
    check("R4", sysRst, 1'b1);
    cyc(3);
    check("R4", sysRst, 1'b0);
    for (int s = 1; s < 4; s++) begin   // R5 each select code
      curReq = "R5"; holdSel = 2'(s);
      supplyOk = 1'b0; cyc(2); supplyOk = 1'b1;
      cyc(holdFor(2'(s)) + 3);
      check("R5", sysRst, 1'b0);
    end
    holdSel = 2'd0;
    curReq = "R3"; manRstN = 1'b0; cyc(DEB - 1); manRstN = 1'b1; cyc(10);
    check("R3", sysRst, 1'b0);          // glitch ignored
    manRstN = 1'b0; cyc(DEB + 4);
    check("R3", sysRst, 1'b1);
    manRstN = 1'b1; curReq = "R4"; cyc(DEB + HA + 5);
    check("R4", sysRst, 1'b0);
    curReq = "R6"; holdSel = 2'd1;
    supplyOk = 1'b0; cyc(2); supplyOk = 1'b1; cyc(6);
    supplyOk = 1'b0; cyc(1); supplyOk = 1'b1; cyc(HB - 2);
    check("R6", sysRst, 1'b1);          // restarted timing
    manRstN = 1'b0; cyc(DEB - 1); manRstN = 1'b1;   // glitch mid-hold
    cyc(HB + 4);
    check("R6", sysRst, 1'b0);
    curReq = "R9"; holdSel = 2'd0;
    supplyOk = 1'b0; manRstN = 1'b0; cyc(DEB + 5);
    supplyOk = 1'b1; cyc(HA + 3);
    check("R9", sysRst, 1'b1);          // button still held
    manRstN = 1'b1; cyc(DEB + 3);
    check("R9", sysRst, 1'b1);
    cyc(HA + 2);
    check("R9", sysRst, 1'b0);
    curReq = "R1"; rstN = 1'b0; cyc(1);
    check("R1", sysRst, 1'b1);
    rstN = 1'b1; cyc(HA + 4);
    check("R1", sysRst, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule